// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block brings a switching-regulator controller out of reset in a fixed, cycle-counted order. It watches two asynchronous qualifiers: a supply-good flag and the output of a comparator that reports whether the enable/compensation pin sits above its threshold. While either qualifier is low, the sequencer holds the power stage off and asks the oscillator to stop. Once both are high, it runs three timed phases: a settling wait, a short strobe that discharges the compensation network to the reference level, and a ramp of a digital offset code that an external DAC subtracts from the feedback reference. After the ramp it enters the run phase, where the gates stay enabled.

The clock is the switching clock, one tick per switching period. The offset code is full scale until the ramp begins. It falls on every ramp cycle and reaches zero on the last one. If either qualifier drops at any point, the sequencer returns to its held state and re-arms, and the next start repeats all three phases from the beginning.

Top module: `softstart_sequencer`

## Requirements
- R1: While `rst_n` is low, and while both qualifiers have not been seen high, the outputs are `osc_stop_o`=1, `gate_en_o`=0, `disch_o`=0, `ss_done_o`=0 and `ofs_code_o`=4095 (all ones).
- R2: Each qualifier passes through two synchronizing flip-flops, so a change is first reflected in the phase after the third rising clock edge that follows it. The outputs keep their previous phase for the two samples in between.
- R3: The settling phase lasts exactly 1024 cycles, with `osc_stop_o`=0, gates off, no discharge and the code at 4095.
- R4: The discharge phase follows and lasts exactly 24 cycles, with `disch_o`=1, gates off and the code at 4095.
- R5: The ramp phase lasts exactly 2048 cycles, with `gate_en_o`=1. On ramp cycle k (0 to 2047), with r = 2047 - k, the code is floor(r*4095/2047). It therefore starts at 4095, falls strictly on each cycle and is 0 on the last ramp cycle.
- R6: Dropping either qualifier in any phase returns the block to the held state of R1, with the latency of R2. The next start runs the full settling, discharge and ramp sequence again.
- R7: In the run phase, entered 3096 cycles after the first settling cycle, `ss_done_o`=1, `gate_en_o`=1 and the code is 0. This holds for as long as both qualifiers stay high.
- R8: At most one of `osc_stop_o`, `disch_o` and `ss_done_o` is high at a time, and `gate_en_o` is never high together with `osc_stop_o` or `disch_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock, one tick per switching period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Supply-good flag, asynchronous |
| en_above_i | input | 1 | Enable/compensation pin above threshold, asynchronous |
| gate_en_o | output | 1 | Permits the upper and lower gate drivers to switch |
| disch_o | output | 1 | Drives the compensation node to the reference level |
| osc_stop_o | output | 1 | Stops the oscillator while the block is held |
| ofs_code_o | output | 12 | Soft-start offset code for the external DAC |
| ss_done_o | output | 1 | Soft-start complete, run phase |

## Verification
The assertions check the following on every cycle: the mutual exclusion of the phase indicators, gates off and a full-scale code whenever the oscillator is stopped, a strictly falling code during the ramp, a return to the held state one cycle after an abort, the exact discharge length, and a zero code on entry to run. The exact settling and ramp lengths, the code values at each ramp step, the two-cycle synchronizer latency and the full restart after an abort can only be shown by the bench scenarios. These scenarios compare every output on every cycle against an independent timeline, across full starts, aborts in each phase, an abort on the last ramp cycle, and a start with only one qualifier raised.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

  typedef enum logic [2:0] {
    PH_HELD   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_DISCH  = 3'd2,
    PH_RAMP   = 3'd3,
    PH_RUN    = 3'd4
  } phase_e;

  // Offset code for a ramp step with 'rem' steps left out of 'span' steps.
  function automatic logic [31:0] ramp_scale(input logic [31:0] rem,
                                             input logic [31:0] span,
                                             input logic [31:0] full);
    logic [63:0] prod;
    if (span == 32'd0) return 32'd0;
    prod = 64'(rem) * 64'(full);
    return 32'(prod / 64'(span));
  endfunction

endpackage

// File: rtl/sst_sync.sv
module sst_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sst_phase_fsm.sv
module sst_phase_fsm
  import softstart_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int DISCH_CYC  = 24,
  parameter int RAMP_CYC   = 2048,
  parameter int CNT_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             abort_o,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] DISCH_LAST  = CNT_W'(DISCH_CYC - 1);
  localparam logic [CNT_W-1:0] RAMP_LAST   = CNT_W'(RAMP_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    phase_d = phase_q;
    if (!arm_i) begin
      phase_d = PH_HELD;
    end else begin
      case (phase_q)
        PH_HELD:   phase_d = PH_SETTLE;
        PH_SETTLE: if (cnt_q == SETTLE_LAST) phase_d = PH_DISCH;
        PH_DISCH:  if (cnt_q == DISCH_LAST)  phase_d = PH_RAMP;
        PH_RAMP:   if (cnt_q == RAMP_LAST)   phase_d = PH_RUN;
        default:   phase_d = PH_RUN;
      endcase
    end
  end

  assign step_o  = (phase_d != phase_q);
  assign abort_o = (phase_q != PH_HELD) && !arm_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HELD;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (step_o || phase_q == PH_HELD || phase_q == PH_RUN) cnt_q <= '0;
      else                                                  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sst_offset_map.sv
module sst_offset_map
  import softstart_pkg::*;
#(
  parameter int RAMP_CYC = 2048,
  parameter int CNT_W    = 12,
  parameter int CODE_W   = 12
) (
  input  phase_e            phase_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [31:0] FULL = 32'((64'd1 << CODE_W) - 64'd1);
  localparam logic [31:0] SPAN = 32'(RAMP_CYC - 1);

  logic [31:0] remain;
  logic [31:0] scaled;

  assign remain = SPAN - 32'(cnt_i);
  assign scaled = ramp_scale(remain, SPAN, FULL);

  always_comb begin
    case (phase_i)
      PH_RAMP: code_o = CODE_W'(scaled);
      PH_RUN:  code_o = '0;
      default: code_o = '1;
    endcase
  end
endmodule

// File: rtl/softstart_sequencer.sv
module softstart_sequencer
  import softstart_pkg::*;
#(
  parameter int SETTLE_CYC  = 1024,
  parameter int DISCH_CYC   = 24,
  parameter int RAMP_CYC    = 2048,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good_i,
  input  logic              en_above_i,
  output logic              gate_en_o,
  output logic              disch_o,
  output logic              osc_stop_o,
  output logic [CODE_W-1:0] ofs_code_o,
  output logic              ss_done_o
);
  localparam int MAX_PH = (SETTLE_CYC > RAMP_CYC) ?
                          ((SETTLE_CYC > DISCH_CYC) ? SETTLE_CYC : DISCH_CYC) :
                          ((RAMP_CYC > DISCH_CYC) ? RAMP_CYC : DISCH_CYC);
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  logic [1:0]       qual_sync;
  logic             arm;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             abort_evt;
  logic             step_evt;

  sst_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({pwr_good_i, en_above_i}),
    .q_o   (qual_sync)
  );

  assign arm = &qual_sync;

  sst_phase_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .DISCH_CYC  (DISCH_CYC),
    .RAMP_CYC   (RAMP_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (arm),
    .phase_o (phase),
    .cnt_o   (cnt),
    .abort_o (abort_evt),
    .step_o  (step_evt)
  );

  sst_offset_map #(
    .RAMP_CYC (RAMP_CYC),
    .CNT_W    (CNT_W),
    .CODE_W   (CODE_W)
  ) u_map (
    .phase_i (phase),
    .cnt_i   (cnt),
    .code_o  (ofs_code_o)
  );

  assign osc_stop_o = (phase == PH_HELD);
  assign disch_o    = (phase == PH_DISCH);
  assign gate_en_o  = (phase == PH_RAMP) || (phase == PH_RUN);
  assign ss_done_o  = (phase == PH_RUN);
endmodule

// File: rtl/softstart_sequencer_chk.sv
module softstart_sequencer_chk #(
  parameter int DISCH_CYC = 24,
  parameter int CODE_W    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_en,
  input logic              disch,
  input logic              osc_stop,
  input logic [CODE_W-1:0] code,
  input logic              done,
  input logic              abort_evt,
  input logic              step_evt
);
  logic [31:0] disch_len;
  logic [31:0] step_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disch_len <= '0;
      step_cnt  <= '0;
    end else begin
      disch_len <= disch ? disch_len + 1 : 32'd0;
      if (step_evt) step_cnt <= step_cnt + 1;
    end
  end

  p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    osc_stop |-> (!gate_en && code == {CODE_W{1'b1}}));

  p_disch_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(disch) && !osc_stop) |-> (disch_len == 32'(DISCH_CYC)));

  p_ramp_desc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !done && $past(gate_en) && !$past(done)) |-> (code < $past(code)));

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> osc_stop);

  p_run_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (code == '0 && gate_en));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({osc_stop, disch, done}) && !(gate_en && (osc_stop || disch)));

  p_step_leaves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && step_cnt != 32'hFFFF_FFFF) |=> !$stable({osc_stop, disch, gate_en, done}));
endmodule

bind softstart_sequencer softstart_sequencer_chk #(
  .DISCH_CYC (DISCH_CYC),
  .CODE_W    (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_en   (gate_en_o),
  .disch     (disch_o),
  .osc_stop  (osc_stop_o),
  .code      (ofs_code_o),
  .done      (ss_done_o),
  .abort_evt (abort_evt),
  .step_evt  (step_evt)
);

// File: tb/softstart_sequencer_tb.sv
module softstart_sequencer_tb_top;
  localparam int SETTLE = 1024;
  localparam int DISCH  = 24;
  localparam int RAMP   = 2048;
  localparam int CW     = 12;
  localparam int FULLC  = (1 << CW) - 1;

  typedef struct packed {
    logic          osc;
    logic          gate;
    logic          dis;
    logic          done;
    logic [CW-1:0] code;
  } obs_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_good = 1'b0;
  logic          en_above = 1'b0;
  logic          gate_en, disch, osc_stop, ss_done;
  logic [CW-1:0] ofs_code;

  int    n_checks = 0;
  int    n_errors = 0;
  bit    finished = 1'b0;
  obs_t  exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  softstart_sequencer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good),
    .en_above_i (en_above),
    .gate_en_o  (gate_en),
    .disch_o    (disch),
    .osc_stop_o (osc_stop),
    .ofs_code_o (ofs_code),
    .ss_done_o  (ss_done)
  );

  function automatic obs_t held_obs();
    obs_t o;
    o.osc = 1'b1; o.gate = 1'b0; o.dis = 1'b0; o.done = 1'b0;
    o.code = CW'(FULLC);
    return o;
  endfunction

  // Timeline from the requirements: k cycles after the first settling cycle.
  function automatic obs_t seq_obs(input int k, output string tag);
    obs_t o;
    real  v;
    int   r;
    o = held_obs();
    o.osc = 1'b0;
    if (k < SETTLE) begin
      tag = "R3";
    end else if (k < SETTLE + DISCH) begin
      tag = "R4"; o.dis = 1'b1;
    end else if (k < SETTLE + DISCH + RAMP) begin
      tag = "R5"; o.gate = 1'b1;
      r = (SETTLE + DISCH + RAMP - 1) - k;
      v = (r * 1.0 * FULLC) / (RAMP - 1);
      o.code = CW'($rtoi(v));
    end else begin
      tag = "R7"; o.gate = 1'b1; o.done = 1'b1; o.code = '0;
    end
    return o;
  endfunction

  // Scoreboard monitor: one expected observation per falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      obs_t  e;
      obs_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{osc_stop, gate_en, disch, ss_done, ofs_code};
      n_checks++;
      if (a !== e) begin
        n_errors++;
        $display("FAIL %s at %0t: osc/gate/dis/done/code actual %b%b%b%b/%0d expected %b%b%b%b/%0d",
                 t, $time, a.osc, a.gate, a.dis, a.done, a.code,
                 e.osc, e.gate, e.dis, e.done, e.code);
      end
    end
  end

  // Driver: raise the given qualifiers for n edges, then drop one of them
  // (or both) and watch 'off' more cycles.
  task automatic run_window(input bit pg, input bit en, input int n,
                            input int off, input bit drop_pg_only);
    pwr_good = pg;
    en_above = en;
    for (int i = 0; i < n + off; i++) begin
      string t;
      obs_t  e;
      if (pg && en && i >= 2 && i <= n + 1) begin
        e = seq_obs(i - 2, t);
      end else begin
        e = held_obs();
        if (i < 2)               t = "R2";
        else if (pg && en)       t = "R6";
        else                     t = "R1";
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    repeat (n) @(negedge clk);
    #1;
    pwr_good = 1'b0;
    if (!drop_pg_only) en_above = 1'b0;
    repeat (off) @(negedge clk);
    #1;
    en_above = 1'b0;
  endtask

  initial begin
    localparam int TOTAL = SETTLE + DISCH + RAMP;
    repeat (3) @(negedge clk);
    #1;
    exp_q.push_back(held_obs()); tag_q.push_back("R1");  // state under reset
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    // R1: only one qualifier high keeps the block held
    run_window(1'b1, 1'b0, 40, 4, 1'b0);
    run_window(1'b0, 1'b1, 40, 4, 1'b0);
    // R3 R4 R5 R7: full start, then abort from run (R6)
    run_window(1'b1, 1'b1, TOTAL + 30, 4, 1'b0);
    // R6: abort in settle, in discharge (supply-good only), in ramp
    run_window(1'b1, 1'b1, 500, 4, 1'b0);
    run_window(1'b1, 1'b1, SETTLE + 10, 4, 1'b1);
    run_window(1'b1, 1'b1, SETTLE + DISCH + 1000, 4, 1'b0);
    // R5 R6: abort arriving on the last ramp cycle, then a full re-armed start
    run_window(1'b1, 1'b1, TOTAL + 1, 4, 1'b0);
    run_window(1'b1, 1'b1, TOTAL + 12, 4, 1'b1);
    wait (exp_q.size() == 0);
    @(negedge clk);
    #1;
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(64'd20 * 64'd150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule